// File: doc/BRIEF.md
# Adaptive Frame-Sync PCM Serial Port

This block moves one companded sample per frame in each direction over a synchronous serial link. The bit clock and the frame sync come from outside the block. It samples them in the local clock domain and finds their edges there. A frame starts on each rising edge of the sync. The transmit byte is shifted out MSB first on a serial line with an output enable, so the line can share a bus with other talkers. Received bits are gathered MSB first into a byte, and a one-cycle strobe marks the byte as ready.

The sync pulse may be short or long. A short pulse covers exactly one falling bit-clock edge. A long pulse covers two or more consecutive falling edges. The block measures each pulse and uses the result to choose the bit timing of the following frame. In short timing the word follows the falling edge that sampled sync. In long timing the word starts at the sync rise itself.

Leaving power-down or reset, the serial output stays released for two whole frames, which keeps it off a bus that is still settling. Pulling the power-up input low releases the output at once and stops reception.

Top module: `pcm_frame_port`

## Requirements
- R1: A sync pulse that is high at two or more consecutive falling bit-clock edges is classed long, and the next frame then uses long timing.
- R2: A sync pulse that is high at exactly one falling bit-clock edge is classed short, and the next frame then uses short timing.
- R3: Each frame uses the class measured on the previous pulse. After reset or power-down the class is short.
- R4: In short timing the output enable rises on the rising bit-clock edge that follows the falling edge which sampled sync. The MSB appears at that point. Each further rising edge presents the next bit. The enable drops on the eighth falling edge after the one that sampled sync, which is the middle of the LSB.
- R5: In short timing, received bits are taken on the first through eighth falling edges after the falling edge that sampled sync, MSB first.
- R6: In long timing the output is driven from the sync rise, with the MSB presented at once. The next bit follows at each rising edge after the first falling edge that sees sync high. The enable drops at whichever comes later: the falling edge in the middle of the LSB (the eighth falling edge, counting the first one that sees sync high as the first), or the fall of sync.
- R7: In long timing, received bits are taken on eight falling edges, MSB first. The first of these is the first falling edge that sees sync high.
- R8: `rx_valid` is high for exactly one clock after the eighth received bit is captured, and `rx_byte` then holds the assembled word.
- R9: The transmit byte is captured when a frame starts: at the sync rise in long timing, and at the falling edge that sampled sync in short timing. Changes to `tx_byte` later in the frame do not alter the word being sent.
- R10: After reset, and after `pwr_up` rises, the output enable stays low through the first two frames. Driving resumes on the third frame start.
- R11: While `pwr_up` is low, `sdo_oe` is low from the next clock onward and no `rx_valid` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | High for normal operation, low for power-down |
| bclk | input | 1 | External bit clock |
| fs | input | 1 | External frame sync |
| sdi | input | 1 | Serial receive data |
| tx_byte | input | WORD_W | Word to send in the next frame |
| sdo | output | 1 | Serial transmit data |
| sdo_oe | output | 1 | High while `sdo` drives the line |
| rx_byte | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | One-clock strobe when `rx_byte` is updated |

## Verification
Every change on `bclk` or `fs` passes through two synchronizer flops and one output register. `sdo`, `sdo_oe` and the receive strobe therefore settle at most three local clocks after the bit-clock edge that causes them. The bench holds each bit-clock phase for six local clocks and samples the outputs four clocks into the phase. This places every check after the result is due and before the next edge can disturb it. The strobe lasts a single clock, so it is counted on every clock, and the count and the captured byte are checked once each frame is over.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

   typedef enum logic {
      FMT_SHORT = 1'b0,
      FMT_LONG  = 1'b1
   } pcm_fmt_t;

   // events handed from the frame controller to the transmitter
   typedef struct packed {
      logic     rise;     // bit clock rising edge seen
      logic     fs_rise;  // sync rising edge seen
      logic     f0;       // first falling edge with sync high
      logic     last;     // falling edge in the middle of the LSB
      pcm_fmt_t fmt;      // timing class of the current frame
      logic     en_now;   // frame may drive the line
      logic     fs_lvl;   // synchronized sync level
   } pcm_tx_ev_t;

endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_flops
      logic [W-1:0] chain [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
         end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end

      assign q = chain[STAGES-1];
   end

endmodule

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl
   import pcm_port_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int LONG_MIN   = 2,
   parameter int ISO_FRAMES = 2,
   parameter int IDX_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_up,
   input  logic             bclk_s,
   input  logic             fs_s,
   output pcm_tx_ev_t       ev,
   output logic [IDX_W-1:0] idx,
   output logic             rx_sample,
   output logic             rx_last,
   output logic             iso_zero
);

   localparam int HI_W  = $clog2(LONG_MIN + 1);
   localparam int ISO_W = $clog2(ISO_FRAMES + 1);

   logic             bclk_q, fs_q;
   logic [HI_W-1:0]  hi_cnt;
   pcm_fmt_t         fmt_next, fmt_cur, fmt_eff;
   logic             active, frame_en, en_now;
   logic [IDX_W-1:0] idx_q, cur_idx;
   logic [ISO_W-1:0] iso_cnt;
   logic             rise, fall, fs_rise, f0, step;

   assign rise    = bclk_s & ~bclk_q;
   assign fall    = ~bclk_s & bclk_q;
   assign fs_rise = fs_s & ~fs_q;
   assign fmt_eff = fs_rise ? fmt_next : fmt_cur;
   assign en_now  = fs_rise ? (iso_cnt == '0) : frame_en;
   assign f0      = pwr_up & fall & fs_s & (hi_cnt == '0);
   assign cur_idx = f0 ? ((fmt_eff == FMT_LONG) ? IDX_W'(1) : IDX_W'(0))
                       : idx_q + IDX_W'(1);
   assign step      = f0 | (pwr_up & fall & active);
   assign rx_sample = step & (cur_idx != IDX_W'(0));
   assign rx_last   = step & (cur_idx == IDX_W'(WORD_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         fs_q   <= 1'b0;
      end else begin
         bclk_q <= bclk_s;
         fs_q   <= fs_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= '0;
         fmt_next <= FMT_SHORT;
         fmt_cur  <= FMT_SHORT;
         active   <= 1'b0;
         idx_q    <= IDX_W'(WORD_W);
         iso_cnt  <= ISO_W'(ISO_FRAMES);
         frame_en <= 1'b0;
      end else if (!pwr_up) begin
         hi_cnt   <= '0;
         fmt_next <= FMT_SHORT;
         fmt_cur  <= FMT_SHORT;
         active   <= 1'b0;
         idx_q    <= IDX_W'(WORD_W);
         iso_cnt  <= ISO_W'(ISO_FRAMES);
         frame_en <= 1'b0;
      end else begin
         if (fs_rise) begin
            fmt_cur  <= fmt_next;
            frame_en <= (iso_cnt == '0);
            if (iso_cnt != '0) iso_cnt <= iso_cnt - ISO_W'(1);
         end
         if (fall) begin
            if (fs_s) begin
               if (hi_cnt != HI_W'(LONG_MIN)) hi_cnt <= hi_cnt + HI_W'(1);
            end else if (hi_cnt != '0) begin
               fmt_next <= (hi_cnt >= HI_W'(LONG_MIN)) ? FMT_LONG : FMT_SHORT;
               hi_cnt   <= '0;
            end
         end
         if (step) begin
            idx_q  <= cur_idx;
            active <= (cur_idx != IDX_W'(WORD_W));
         end
      end
   end

   assign ev.rise    = rise;
   assign ev.fs_rise = fs_rise;
   assign ev.f0      = f0;
   assign ev.last    = rx_last;
   assign ev.fmt     = fmt_eff;
   assign ev.en_now  = en_now;
   assign ev.fs_lvl  = fs_s;
   assign idx        = idx_q;
   assign iso_zero   = (iso_cnt == '0);

endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
   import pcm_port_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_up,
   input  pcm_tx_ev_t        ev,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] tx_byte,
   output logic              sdo,
   output logic              sdo_oe
);

   logic [WORD_W-1:0] sr;
   logic              sending;
   pcm_fmt_t          lng;
   logic              load_long, load_short, rise_w;

   assign load_long  = ev.fs_rise & (ev.fmt == FMT_LONG) & ev.en_now;
   assign load_short = ev.f0 & (ev.fmt == FMT_SHORT) & ev.en_now;
   assign rise_w     = ev.rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr      <= '0;
         sending <= 1'b0;
         sdo_oe  <= 1'b0;
         lng     <= FMT_SHORT;
      end else if (!pwr_up) begin
         sending <= 1'b0;
         sdo_oe  <= 1'b0;
      end else if (load_long) begin
         sr      <= tx_byte;
         sending <= 1'b1;
         sdo_oe  <= 1'b1;
         lng     <= FMT_LONG;
      end else if (load_short) begin
         sr      <= tx_byte;
         sending <= 1'b1;
         lng     <= FMT_SHORT;
      end else begin
         if (ev.rise && sending) begin
            if (idx == '0) sdo_oe <= 1'b1;
            else if (idx < IDX_W'(WORD_W)) sr <= {sr[WORD_W-2:0], 1'b0};
         end
         if (ev.last) sending <= 1'b0;
         if ((ev.last || !sending) && (lng == FMT_SHORT || !ev.fs_lvl))
            sdo_oe <= 1'b0;
      end
   end

   assign sdo = sr[WORD_W-1];

   AST_PD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_up |=> !sdo_oe);                                          // R11
   AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe && $past(sdo_oe) && !$past(rise_w) |-> $stable(sdo));   // R4

endmodule

// File: rtl/pcm_rx.sv
module pcm_rx #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_up,
   input  logic              sdi_s,
   input  logic              sample,
   input  logic              last,
   output logic [WORD_W-1:0] rx_byte,
   output logic              rx_valid
);

   logic [WORD_W-2:0] acc;
   logic [WORD_W-1:0] word_next;

   assign word_next = {acc, sdi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         rx_byte  <= '0;
         rx_valid <= 1'b0;
      end else if (!pwr_up) begin
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= last;
         if (sample) acc <= word_next[WORD_W-2:0];
         if (last) rx_byte <= word_next;
      end
   end

   AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);                                       // R8

endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
   import pcm_port_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ISO_FRAMES  = 2,
   parameter int LONG_MIN    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_up,
   input  logic              bclk,
   input  logic              fs,
   input  logic              sdi,
   input  logic [WORD_W-1:0] tx_byte,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [WORD_W-1:0] rx_byte,
   output logic              rx_valid
);

   localparam int IDX_W = $clog2(WORD_W + 1);

   if (WORD_W < 2) begin : g_bad_word
      $error("pcm_frame_port: WORD_W must be at least 2");
   end
   if (ISO_FRAMES < 1) begin : g_bad_iso
      $error("pcm_frame_port: ISO_FRAMES must be at least 1");
   end
   if (LONG_MIN < 2) begin : g_bad_long
      $error("pcm_frame_port: LONG_MIN must be at least 2");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("pcm_frame_port: SYNC_STAGES must not be negative");
   end

   logic             bclk_s, fs_s, sdi_s;
   pcm_tx_ev_t       ev;
   logic [IDX_W-1:0] idx;
   logic             rx_sample, rx_last, iso_zero;

   pcm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bclk, fs, sdi}),
      .q     ({bclk_s, fs_s, sdi_s})
   );

   pcm_frame_ctl #(
      .WORD_W(WORD_W), .LONG_MIN(LONG_MIN), .ISO_FRAMES(ISO_FRAMES), .IDX_W(IDX_W)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_up    (pwr_up),
      .bclk_s    (bclk_s),
      .fs_s      (fs_s),
      .ev        (ev),
      .idx       (idx),
      .rx_sample (rx_sample),
      .rx_last   (rx_last),
      .iso_zero  (iso_zero)
   );

   pcm_tx #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_up  (pwr_up),
      .ev      (ev),
      .idx     (idx),
      .tx_byte (tx_byte),
      .sdo     (sdo),
      .sdo_oe  (sdo_oe)
   );

   pcm_rx #(.WORD_W(WORD_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_up   (pwr_up),
      .sdi_s    (sdi_s),
      .sample   (rx_sample),
      .last     (rx_last),
      .rx_byte  (rx_byte),
      .rx_valid (rx_valid)
   );

   AST_ISO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> iso_zero);                                   // R10

endmodule

// File: tb/pcm_frame_port_bench.sv
module pcm_frame_port_bench;

   localparam int W  = 8;
   localparam int NC = 16;   // bit clocks per frame

   logic         clk = 1'b0;
   logic         rst_n, pwr_up, bclk, fs, sdi;
   logic [W-1:0] tx_byte;
   logic         sdo, sdo_oe, rx_valid;
   logic [W-1:0] rx_byte;

   int checks = 0;
   int errors = 0;
   int vcnt = 0;
   logic [W-1:0] vbyte;
   int iso_left = 2;
   bit mode_long = 1'b0;
   int fnum = 0;

   always #2 clk = ~clk;

   pcm_frame_port u_pcm_frame_port (
      .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .bclk(bclk), .fs(fs),
      .sdi(sdi), .tx_byte(tx_byte), .sdo(sdo), .sdo_oe(sdo_oe),
      .rx_byte(rx_byte), .rx_valid(rx_valid)
   );

   always @(negedge clk) begin
      if (rx_valid === 1'b1) begin
         vcnt  = vcnt + 1;
         vbyte = rx_byte;
      end
   end

   task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_oe(bit lng, int L, int c, bit hi);
      if (!lng) return hi ? (c >= 1 && c <= 8) : (c >= 1 && c <= 7);
      return hi ? (c <= 7 || c < L) : (c <= 6 || c < L);
   endfunction

   function automatic bit bit_due(bit lng, int c);
      return lng ? (c <= 7) : (c >= 1 && c <= 8);
   endfunction

   function automatic logic exp_bit(bit lng, logic [W-1:0] b, int c);
      return lng ? b[7-c] : b[8-c];
   endfunction

   task automatic phase_check(input int c, input bit hi, input bit en, input bit lng,
                              input int L, input logic [W-1:0] txb, input string ctx);
      bit e;
      string req;
      e   = en && exp_oe(lng, L, c, hi);
      req = lng ? "R1/R6" : "R2/R4";
      check_val($sformatf("%s/R3 %s oe frame %0d cycle %0d %s", req, ctx, fnum, c,
                hi ? "high" : "low"), sdo_oe, e);
      if (e && bit_due(lng, c))
         check_val($sformatf("%s/R9 sdo frame %0d cycle %0d", req, fnum, c),
                   sdo, exp_bit(lng, txb, c));
   endtask

   task automatic run_frame(input logic [W-1:0] txb, input logic [W-1:0] rxb,
                            input int L, input int pd_cycle);
      bit en, lng, powered, iso;
      int vexp;
      string ctx;
      fnum++;
      lng     = mode_long;
      powered = pwr_up;
      iso     = powered && (iso_left != 0);
      en      = powered && !iso;
      if (powered && iso_left > 0) iso_left--;
      tx_byte = txb;
      vcnt    = 0;
      for (int c = 0; c < NC; c++) begin
         bit en_c;
         if (c == pd_cycle) pwr_up = 1'b0;
         en_c = en && !(pd_cycle >= 0 && c >= pd_cycle);
         ctx  = iso ? "R10" : ((pd_cycle >= 0 && c >= pd_cycle) ? "R11" : "");
         bclk = 1'b1;
         fs   = (c < L);
         if (lng && c <= 7)                sdi = rxb[7-c];
         else if (!lng && c >= 1 && c <= 8) sdi = rxb[8-c];
         else                               sdi = 1'($urandom);
         if (c == 2) tx_byte = W'($urandom);   // R9 late change
         repeat (4) @(negedge clk);
         phase_check(c, 1'b1, en_c, lng, L, txb, ctx);
         repeat (2) @(negedge clk);
         bclk = 1'b0;
         repeat (4) @(negedge clk);
         phase_check(c, 1'b0, en_c, lng, L, txb, ctx);
         repeat (2) @(negedge clk);
      end
      vexp = (powered && pd_cycle < 0) ? 1 : 0;
      check_val($sformatf("R8/R11 strobe count frame %0d", fnum), vcnt, vexp);
      if (vexp == 1 && vcnt == 1)
         check_val($sformatf("%s/R8 rx byte frame %0d", lng ? "R7" : "R5", fnum), vbyte, rxb);
      if (!powered || pd_cycle >= 0) begin
         mode_long = 1'b0;
         iso_left  = 2;
      end else begin
         mode_long = (L >= 2);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; pwr_up = 1'b1; bclk = 1'b0; fs = 1'b0; sdi = 1'b0; tx_byte = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_val("R10 reset oe", sdo_oe, 0);
      check_val("R8 reset strobe", rx_valid, 0);
      // two isolated frames; a long pulse while the class is still short
      run_frame(8'hA5, 8'h3C, 5, -1);
      run_frame(8'h5A, 8'hC3, 1, -1);
      // driven frames, corner cases of the class decision
      run_frame(8'h81, 8'h7E, 1, -1);
      run_frame(8'hF0, 8'h0F, 10, -1);
      run_frame(8'h96, 8'h69, 10, -1);
      run_frame(8'h01, 8'h80, 2, -1);
      run_frame(8'hFF, 8'h00, 1, -1);
      run_frame(8'h00, 8'hFF, 3, -1);
      for (int k = 0; k < 30; k++) begin
         int L;
         L = (($urandom % 3) == 0) ? 1 : 2 + int'($urandom % 9);
         run_frame(W'($urandom), W'($urandom), L, -1);
      end
      // drop power in a driven long-class frame, then a frame fully off
      run_frame(8'hC6, 8'h39, 3, -1);
      run_frame(8'h6C, 8'h93, 3, 3);
      run_frame(8'h12, 8'h34, 2, -1);
      pwr_up = 1'b1;
      run_frame(8'h55, 8'hAA, 4, -1);
      run_frame(8'hAA, 8'h55, 2, -1);
      run_frame(8'h3E, 8'hE3, 1, -1);
      run_frame(8'hB2, 8'h2B, 1, -1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule